// File: doc/BRIEF.md
# Dual-Channel Bitstream Converter Digital Core

This block holds the digital side of a charge-balancing bitstream converter with two channels. Each channel has a comparator-style input bit from the analog side and returns a feedback bit that drives an external RC network. On every sample tick, each feedback bit is set to the inverse of the channel's synchronized input. This pushes the capacitor voltage back toward the comparator threshold. The density of ones in the feedback stream is therefore proportional to the input voltage.

A single window counter, shared by both channels, spans 256 ticks. Over that window, each channel counts the ticks on which its feedback bit was set. When the counter wraps, both counts are published together as 8-bit results and the counts start again from zero. A one-cycle valid strobe marks each publication. A count that would reach 256 (input low on every tick of the window) is held at 255. A full-scale input therefore reads 0xFF and does not wrap to zero.

Top module: `dual_bitstream_adc`

## Requirements
- R1: On a cycle where `tick_en` is 1, each `fb_out[c]` becomes the complement of that channel's synchronized input. It is visible from the following cycle.
- R2: On a cycle where `tick_en` is 0, `fb_out`, the window position and both channel counts keep their values, whatever `cmp_in` does.
- R3: At each publication, a channel's result equals the number of ticks in the just-finished 256-tick window on which its synchronized input was 0.
- R4: A count is held at 255. A window in which the input is 0 on all 256 ticks publishes 0xFF.
- R5: Both results are published on the 256th tick of each window, counted from reset. `result_valid` is 1 only in the single cycle that follows that tick.
- R6: Between publications, `result0` and `result1` hold their previous values.
- R7: Each window's count starts from zero. A result depends only on the ticks of its own window.
- R8: `cmp_in` passes through a two-stage synchronizer. A tick in the cycle right after an input change still uses the old level.
- R9: While `rst_n` is 0, the window position and both counts are cleared, the results read 0, `fb_out` is 0 and `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sample tick, one cycle wide |
| cmp_in | input | 2 | Comparator input bit per channel (bit 0 = channel 0) |
| fb_out | output | 2 | Feedback bit per channel to the RC network |
| result0 | output | 8 | Published count of channel 0 |
| result1 | output | 8 | Published count of channel 1 |
| result_valid | output | 1 | One-cycle strobe when both results update |

## Verification
A wrong window position does not show up until a publication. `result_valid` then arrives on the wrong tick, up to 256 ticks late or early. A corrupted channel count also stays hidden until the next wrap, where the published value is off. A wrong feedback value shows on `fb_out` in the cycle after the tick that produced it. Because the counts clear at each wrap, an error that does not touch the window counter affects only one window's results.

// File: rtl/bsadc_pkg.sv
package bsadc_pkg;
    localparam int NUM_CH = 2;

    function automatic logic [7:0] unused_marker();
        return 8'h00;
    endfunction
endpackage

// File: rtl/bsadc_sync.sv
module bsadc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bsadc_window.sv
module bsadc_window #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic wrap_o
);
    localparam logic [CNT_W-1:0] LAST = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (tick_en) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = (cnt_q == LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bsadc_chan.sv
module bsadc_chan #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wrap_i,
    input  logic             level_i,
    output logic             fb_o,
    output logic [RES_W-1:0] result_o
);
    localparam logic [RES_W-1:0] CEIL = '1;

    typedef struct packed {
        logic             fb;
        logic [RES_W-1:0] acc;
        logic [RES_W-1:0] res;
    } chan_t;

    chan_t st_d, st_q;
    logic [RES_W-1:0] acc_step;

    always_comb begin
        st_d     = st_q;
        acc_step = st_q.acc;
        if (tick_en) begin
            st_d.fb = ~level_i;
            if (~level_i && (st_q.acc != CEIL)) begin
                acc_step = st_q.acc + 1'b1;
            end
            if (wrap_i) begin
                st_d.res = acc_step;
                st_d.acc = '0;
            end else begin
                st_d.acc = acc_step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fb_o     = st_q.fb;
    assign result_o = st_q.res;
endmodule

// File: rtl/dual_bitstream_adc.sv
module dual_bitstream_adc
    import bsadc_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       cmp_in,
    output logic [1:0]       fb_out,
    output logic [RES_W-1:0] result0,
    output logic [RES_W-1:0] result1,
    output logic             result_valid
);
    logic [NUM_CH-1:0] lvl_sync;
    logic              wrap;
    logic [RES_W-1:0]  res_arr [NUM_CH];
    logic              valid_d, valid_q;

    bsadc_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cmp_in),
        .sync_o (lvl_sync)
    );

    bsadc_window #(.CNT_W(RES_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .wrap_o (wrap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bsadc_chan #(.RES_W(RES_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .wrap_i  (wrap),
            .level_i (lvl_sync[c]),
            .fb_o    (fb_out[c]),
            .result_o(res_arr[c])
        );
    end

    always_comb begin
        valid_d = wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    assign result0      = res_arr[0];
    assign result1      = res_arr[1];
    assign result_valid = valid_q;
endmodule

// File: rtl/bsadc_checker.sv
module bsadc_checker #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [1:0]       lvl_sync,
    input logic [1:0]       fb_out,
    input logic [RES_W-1:0] result0,
    input logic [RES_W-1:0] result1,
    input logic             result_valid
);
    // R1
    fb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (fb_out == ~$past(lvl_sync)));

    // R2
    fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(fb_out));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R5
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(tick_en));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(result0) && $stable(result1)));
endmodule

bind dual_bitstream_adc bsadc_checker #(.RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .lvl_sync    (lvl_sync),
    .fb_out      (fb_out),
    .result0     (result0),
    .result1     (result1),
    .result_valid(result_valid)
);

// File: tb/tb_dual_bitstream_adc.sv
module tb_dual_bitstream_adc;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 6;
    localparam int LOW0 [N_VEC] = '{0,   256, 128, 255, 1,   200};
    localparam int LOW1 [N_VEC] = '{256, 0,   64,  1,   254, 17};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] cmp_in = 2'b11;
    logic [1:0] fb_out;
    logic [7:0] result0, result1;
    logic       result_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int prev0 = 0;
    int prev1 = 0;

    dual_bitstream_adc dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmp_in(cmp_in),
        .fb_out(fb_out), .result0(result0), .result1(result1),
        .result_valid(result_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic i0, input logic i1);
        @(negedge clk);
        cmp_in = {i1, i0};
        repeat (3) @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    // idle_at >= 0 inserts 300 idle cycles with both inputs low before that tick
    // fast_at >= 0 makes that tick follow an input change by one cycle (channel 0 low)
    task automatic run_window(input int lo0, input int lo1, input int idle_at, input int fast_at);
        for (int t = 0; t < 256; t++) begin
            logic i0, i1;
            i0 = (t < lo0) ? 1'b0 : 1'b1;
            i1 = (t < lo1) ? 1'b0 : 1'b1;
            if (t == idle_at) begin
                logic [1:0] fb_before;
                fb_before = fb_out;
                @(negedge clk);
                cmp_in = 2'b00;
                repeat (300) @(negedge clk);
                // R2: no tick, so feedback must not move
                chk(fb_out == fb_before, "R2 fb idle", fb_out, fb_before);
            end
            if (t == fast_at) begin
                @(negedge clk);
                cmp_in = {i1, 1'b0};
                tick_en = 1'b1;
                @(negedge clk);
                tick_en = 1'b0;
                // R8: synchronizer still shows old high level, fb stays 0
                chk(fb_out[0] == 1'b0, "R8 sync delay", fb_out[0], 0);
                @(negedge clk);
                cmp_in = {i1, i0};
                repeat (3) @(negedge clk);
            end else begin
                do_tick(i0, i1);
            end
            if (t == 0) begin
                // R1
                chk(fb_out == ~{i1, i0}, "R1 fb complement", fb_out, ~{i1, i0} & 2'b11);
            end
            if (t == 128) begin
                // R6
                chk(result0 == prev0[7:0], "R6 hold ch0", result0, prev0);
                chk(result1 == prev1[7:0], "R6 hold ch1", result1, prev1);
            end
            if (t == 254) begin
                // R5
                chk(result_valid == 1'b0, "R5 no early valid", result_valid, 0);
            end
            if (t == 255) begin
                // R3 R4 R5 R7
                chk(result_valid == 1'b1, "R5 valid on 256th tick", result_valid, 1);
                chk(result0 == sat(lo0), "R3/R4/R7 ch0", result0, sat(lo0));
                chk(result1 == sat(lo1), "R3/R4/R7 ch1", result1, sat(lo1));
                @(negedge clk);
                chk(result_valid == 1'b0, "R5 valid one cycle", result_valid, 0);
                prev0 = sat(lo0);
                prev1 = sat(lo1);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(result0 == 0 && result1 == 0, "R9 reset results", {result1, result0}, 0);
        chk(fb_out == 2'b00, "R9 reset fb", fb_out, 0);
        chk(result_valid == 1'b0, "R9 reset valid", result_valid, 0);
        rst_n = 1'b1;

        for (int v = 0; v < N_VEC; v++) begin
            run_window(LOW0[v], LOW1[v], -1, -1);
        end

        // R2: idle cycles with low inputs must not add counts
        run_window(10, 20, 100, -1);

        // R9: reset in the middle of a window
        for (int t = 0; t < 50; t++) do_tick(1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(result0 == 0 && result1 == 0, "R9 mid reset results", {result1, result0}, 0);
        chk(fb_out == 2'b00, "R9 mid reset fb", fb_out, 0);
        chk(result_valid == 1'b0, "R9 mid reset valid", result_valid, 0);
        rst_n = 1'b1;
        prev0 = 0;
        prev1 = 0;
        // fresh window from cleared counter, with the R8 fast tick inside
        run_window(0, 0, -1, 40);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule